// File: doc/BRIEF.md
# Static Memory Wait-State Inserter

This block sits in front of the access sequencer of a static memory controller and decides whether an idle cycle must separate two consecutive accesses. A host programs four registers per chip select (setup, pulse, cycle and mode) through a small write port. Those writes land in a staged copy. The sequencer only ever sees an active copy, which the block updates during an inserted wait cycle.

Writing the mode register of any chip select marks a reload as pending. The next access then pays exactly one wait cycle, during which the whole staged set is copied into the active set. A change of chip select already costs one wait cycle, and that cycle also absorbs the pending reload. A read that directly follows a write whose end is set by the write strobe and that has no hold time gets one early-read wait cycle.

Each access is requested with its chip select, its direction and its write-control mode. The request is held until the block grants it. The sequencer reports the end of the access on a done pulse.

Top module: `smw_wait_inserter`

## Requirements
- R1: After reset, wait_type is 0, grant is 0, every active parameter reads 0, and the first access is granted with no wait cycle.
- R2: Host writes to the setup (cfg_sel=0), pulse (cfg_sel=1) or cycle (cfg_sel=2) register leave the active parameters unchanged and cause no reload wait cycle.
- R3: A host write to a mode register (cfg_sel=3) makes the next access from the same chip select as the previous access show one wait cycle of type 2 (reload). After that access, the active parameters equal the staged values.
- R4: The reload wait cycle is inserted for a same-chip-select access even when the mode write concerned a different chip select, and that other chip select's active values are updated too.
- R5: When the requested chip select differs from the previous access, exactly one wait cycle of type 1 is shown. This cycle also performs any pending reload, so the following same-chip-select access gets no reload wait.
- R6: A read that follows a write with req_wec=1 and zero hold (active cycle ≤ setup + pulse for that chip select) gets one wait cycle of type 3. No early-read wait is given after a read, after a write with req_wec=0, or after a write with nonzero hold.
- R7: When several wait causes apply, only one wait cycle is inserted, with priority chip-select change (1) over reload (2) over early read (3).
- R8: With req_valid low, wait_type stays 0 and a pending reload stays pending until the next request.
- R9: grant is high for exactly one cycle per access, in the cycle after any wait cycle. No further grant is given until acc_done has been pulsed.
- R10: A mode write in the same cycle as a reload copy leaves the reload pending. The next access pays a reload wait again, and only then does the newly written value become active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_cs | input | CS_W | Chip select addressed by the host write |
| cfg_sel | input | 2 | Register select: 0 setup, 1 pulse, 2 cycle, 3 mode |
| cfg_data | input | CFG_W | Value written to the staged register |
| req_valid | input | 1 | Access request, held until grant |
| req_cs | input | CS_W | Chip select of the request; also selects the active parameters shown |
| req_write | input | 1 | 1 write, 0 read |
| req_wec | input | 1 | Write end controlled by the write strobe |
| acc_done | input | 1 | Pulse: the granted access has finished |
| wait_type | output | 2 | 0 none, 1 chip-select change, 2 reload, 3 early read |
| grant | output | 1 | One-cycle start of the requested access |
| act_setup | output | CFG_W | Active setup value for req_cs |
| act_pulse | output | CFG_W | Active pulse value for req_cs |
| act_cycle | output | CFG_W | Active cycle value for req_cs |
| act_mode | output | CFG_W | Active mode value for req_cs |

## Verification
The assertions assume that a request, once raised, keeps its fields unchanged until it is granted. They also assume that acc_done is pulsed only after a grant. Under these assumptions, every wait cycle is followed by a grant and no grant follows another grant. The bench drives each request from one access task that holds it steady until the grant, and pulses done once per granted access. The one deliberate deviation holds the request high after its grant, in order to check that no second grant appears while the access is open.

// File: rtl/smw_pkg.sv
package smw_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        WT_NONE   = 2'd0,
        WT_CSW    = 2'd1,
        WT_RELOAD = 2'd2,
        WT_EARLY  = 2'd3
    } wait_t;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_CYCLE = 2'd2,
        SEL_MODE  = 2'd3
    } cfg_sel_t;

    typedef struct packed {
        logic [CFG_W-1:0] setup;
        logic [CFG_W-1:0] pulse;
        logic [CFG_W-1:0] cycle;
        logic [CFG_W-1:0] mode;
    } cs_params_t;

    // Write hold is cycle minus (setup + pulse); zero when not positive.
    function automatic logic hold_is_zero(cs_params_t p);
        logic [CFG_W:0] sum;
        sum = {1'b0, p.setup} + {1'b0, p.pulse};
        return ({1'b0, p.cycle} <= sum);
    endfunction

endpackage

// File: rtl/smw_cfg_bank.sv
module smw_cfg_bank
    import smw_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CS_W-1:0]  cfg_cs,
    input  cfg_sel_t         cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             copy,
    input  logic [CS_W-1:0]  rd_cs,
    output cs_params_t       rd_params,
    output logic             pend,
    output logic             mode_wr
);

    cs_params_t staged_q [NUM_CS];
    cs_params_t active_q [NUM_CS];

    assign mode_wr = cfg_wr && (cfg_sel == SEL_MODE);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        logic hit;
        assign hit = cfg_wr && (cfg_cs == CS_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                staged_q[i] <= '0;
            end else if (hit) begin
                case (cfg_sel)
                    SEL_SETUP: staged_q[i].setup <= cfg_data;
                    SEL_PULSE: staged_q[i].pulse <= cfg_data;
                    SEL_CYCLE: staged_q[i].cycle <= cfg_data;
                    default:   staged_q[i].mode  <= cfg_data;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                active_q[i] <= '0;
            end else if (copy) begin
                active_q[i] <= staged_q[i];
            end
        end

        // Active parameters move only in a reload copy cycle.
        assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !copy |=> $stable(active_q[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (mode_wr) begin
            pend <= 1'b1;
        end else if (copy) begin
            pend <= 1'b0;
        end
    end

    assign rd_params = active_q[rd_cs];

    assert_mode_sets_pend_R3: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> pend);

    assert_copy_rearm_R10: assert property (@(posedge clk) disable iff (rst)
        (copy && mode_wr) |=> pend);

endmodule

// File: rtl/smw_seq.sv
module smw_seq
    import smw_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [CS_W-1:0] req_cs,
    input  logic            req_write,
    input  logic            req_wec,
    input  logic            acc_done,
    input  logic            pend,
    input  logic            hold_zero,
    output wait_t           wait_type,
    output logic            grant,
    output logic            copy
);

    logic            busy_q;
    logic            waited_q;
    logic            prev_valid_q;
    logic [CS_W-1:0] prev_cs_q;
    logic            prev_nohold_q;
    wait_t           cand;
    logic            eval;

    always_comb begin
        cand = WT_NONE;
        if (prev_valid_q && (req_cs != prev_cs_q)) begin
            cand = WT_CSW;
        end else if (pend) begin
            cand = WT_RELOAD;
        end else if (prev_nohold_q && !req_write) begin
            cand = WT_EARLY;
        end
    end

    assign eval      = req_valid && !busy_q;
    assign wait_type = (eval && !waited_q) ? cand : WT_NONE;
    assign grant     = eval && (waited_q || (cand == WT_NONE));
    assign copy      = pend && ((wait_type == WT_CSW) || (wait_type == WT_RELOAD));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q        <= 1'b0;
            waited_q      <= 1'b0;
            prev_valid_q  <= 1'b0;
            prev_cs_q     <= '0;
            prev_nohold_q <= 1'b0;
        end else begin
            if (acc_done) begin
                busy_q <= 1'b0;
            end
            if (grant) begin
                busy_q        <= 1'b1;
                waited_q      <= 1'b0;
                prev_valid_q  <= 1'b1;
                prev_cs_q     <= req_cs;
                prev_nohold_q <= req_write && req_wec && hold_zero;
            end else if (wait_type != WT_NONE) begin
                waited_q <= 1'b1;
            end
        end
    end

    assert_grant_single_R9: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);

    assert_wait_then_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (wait_type != WT_NONE) |=> grant);

    assert_idle_nowait_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (wait_type == WT_NONE));

endmodule

// File: rtl/smw_wait_inserter.sv
module smw_wait_inserter
    import smw_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CS_W-1:0]  cfg_cs,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             req_valid,
    input  logic [CS_W-1:0]  req_cs,
    input  logic             req_write,
    input  logic             req_wec,
    input  logic             acc_done,
    output logic [1:0]       wait_type,
    output logic             grant,
    output logic [CFG_W-1:0] act_setup,
    output logic [CFG_W-1:0] act_pulse,
    output logic [CFG_W-1:0] act_cycle,
    output logic [CFG_W-1:0] act_mode
);

    cs_params_t rd_params;
    logic       pend;
    logic       mode_wr;
    logic       copy;
    wait_t      wt;

    smw_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_cs    (cfg_cs),
        .cfg_sel   (cfg_sel_t'(cfg_sel)),
        .cfg_data  (cfg_data),
        .copy      (copy),
        .rd_cs     (req_cs),
        .rd_params (rd_params),
        .pend      (pend),
        .mode_wr   (mode_wr)
    );

    smw_seq #(.NUM_CS(NUM_CS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cs    (req_cs),
        .req_write (req_write),
        .req_wec   (req_wec),
        .acc_done  (acc_done),
        .pend      (pend),
        .hold_zero (hold_is_zero(rd_params)),
        .wait_type (wt),
        .grant     (grant),
        .copy      (copy)
    );

    assign wait_type = wt;
    assign act_setup = rd_params.setup;
    assign act_pulse = rd_params.pulse;
    assign act_cycle = rd_params.cycle;
    assign act_mode  = rd_params.mode;

    // A chip-select change wait also consumes the pending reload.
    assert_csw_reloads_R5: assert property (@(posedge clk) disable iff (rst)
        ((wt == WT_CSW) && pend && !mode_wr) |=> !pend);

endmodule

// File: tb/smw_wait_inserter_tb_top.sv
module smw_wait_inserter_tb_top;

    localparam int NUM_CS = 4;
    localparam int CS_W = 2;
    localparam int CFG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [CS_W-1:0]  cfg_cs = '0;
    logic [1:0]       cfg_sel = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic             req_valid = 1'b0;
    logic [CS_W-1:0]  req_cs = '0;
    logic             req_write = 1'b0;
    logic             req_wec = 1'b0;
    logic             acc_done = 1'b0;
    logic [1:0]       wait_type;
    logic             grant;
    logic [CFG_W-1:0] act_setup, act_pulse, act_cycle, act_mode;

    always #2 clk = ~clk;

    smw_wait_inserter #(.NUM_CS(NUM_CS)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_cs(req_cs),
        .req_write(req_write), .req_wec(req_wec), .acc_done(acc_done),
        .wait_type(wait_type), .grant(grant), .act_setup(act_setup),
        .act_pulse(act_pulse), .act_cycle(act_cycle), .act_mode(act_mode)
    );

    typedef struct {
        bit       is_grant;
        bit [1:0] wt;
        string    tag;
    } exp_t;

    exp_t sb_q[$];
    int   errors = 0;
    int   checks = 0;
    int   cycles = 0;

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    // Monitor: every wait cycle or grant must match the next expected item.
    always @(negedge clk) begin
        if (!rst && (wait_type != 2'd0 || grant)) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected event, actual wait=%0d grant=%0d expected none",
                         "R9", wait_type, grant);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_grant) begin
                    if (!(grant && wait_type == 2'd0)) begin
                        errors++;
                        $display("FAIL %s: actual wait=%0d grant=%0d expected grant with wait=0",
                                 e.tag, wait_type, grant);
                    end
                end else if (grant || wait_type != e.wt) begin
                    errors++;
                    $display("FAIL %s: actual wait=%0d grant=%0d expected wait=%0d grant=0",
                             e.tag, wait_type, grant, e.wt);
                end
            end
        end
    end

    task automatic cfg_write(input int cs, input int sel, input int data);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_cs = CS_W'(cs); cfg_sel = 2'(sel); cfg_data = CFG_W'(data);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Driver: pushes expected items, holds the request until grant, then completes.
    task automatic access(input int cs, input bit wr, input bit wec, input int exp_wt,
                          input string tag, input int extra_hold = 0,
                          input bit with_mode = 1'b0, input int mode_val = 0);
        exp_t e;
        if (exp_wt != 0) begin
            e.is_grant = 1'b0; e.wt = 2'(exp_wt); e.tag = tag;
            sb_q.push_back(e);
        end
        e.is_grant = 1'b1; e.wt = 2'd0; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b1; req_cs = CS_W'(cs); req_write = wr; req_wec = wec;
        if (with_mode) begin
            cfg_wr = 1'b1; cfg_cs = CS_W'(cs); cfg_sel = 2'd3; cfg_data = CFG_W'(mode_val);
        end
        forever begin
            @(negedge clk);
            if (grant) break;
            if (with_mode) begin
                #0;
            end
        end
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        for (int i = 0; i < extra_hold; i++) begin
            @(posedge clk); #1;
        end
        req_valid = 1'b0; acc_done = 1'b1;
        @(posedge clk); #1;
        acc_done = 1'b0;
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d expected items left, expected 0", tag, sb_q.size());
            sb_q.delete();
        end
    endtask

    task automatic check_act(input int cs, input int s, input int p, input int c,
                             input int m, input string tag);
        @(posedge clk); #1;
        req_cs = CS_W'(cs);
        @(negedge clk);
        checks++;
        if (act_setup != CFG_W'(s) || act_pulse != CFG_W'(p) ||
            act_cycle != CFG_W'(c) || act_mode != CFG_W'(m)) begin
            errors++;
            $display("FAIL %s: cs%0d actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, cs, act_setup, act_pulse, act_cycle, act_mode, s, p, c, m);
        end
    endtask

    initial begin
        idle(3);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (wait_type != 2'd0 || grant) begin
            errors++;
            $display("FAIL R1: reset actual wait=%0d grant=%0d expected 0/0", wait_type, grant);
        end
        check_act(0, 0, 0, 0, 0, "R1");
        access(0, 0, 0, 0, "R1");

        cfg_write(0, 0, 1); cfg_write(0, 1, 2); cfg_write(0, 2, 3);
        check_act(0, 0, 0, 0, 0, "R2");
        access(0, 0, 0, 0, "R2");

        cfg_write(0, 3, 5);
        idle(5);                               // R8: no request, no wait, reload kept
        access(0, 1, 1, 2, "R8");              // R3 reload wait on same cs
        check_act(0, 1, 2, 3, 5, "R3");
        access(0, 0, 0, 3, "R6");              // zero-hold strobe write then read
        access(0, 0, 0, 0, "R6");              // read after read

        cfg_write(2, 3, 7);
        access(0, 0, 0, 2, "R4");
        check_act(2, 0, 0, 0, 7, "R4");

        access(0, 1, 1, 0, "R6");
        cfg_write(1, 3, 1);
        access(1, 0, 0, 1, "R7");              // cs change beats reload and early read
        access(1, 0, 0, 0, "R5");              // no extra reload wait
        check_act(1, 0, 0, 0, 1, "R5");

        access(1, 1, 1, 0, "R7");
        cfg_write(1, 3, 2);
        access(1, 0, 0, 2, "R7");              // reload beats early read
        access(1, 0, 0, 0, "R7");

        cfg_write(1, 2, 9); cfg_write(1, 3, 3);
        access(1, 1, 1, 2, "R3");
        access(1, 0, 0, 0, "R6");              // nonzero hold: no early read
        access(1, 1, 0, 0, "R6");
        access(1, 0, 0, 0, "R6");              // not strobe-controlled: no early read

        cfg_write(1, 3, 4);
        access(1, 0, 0, 2, "R10", 0, 1'b1, 6);
        check_act(1, 0, 0, 9, 4, "R10");
        access(1, 0, 0, 2, "R10");
        check_act(1, 0, 0, 9, 6, "R10");

        access(1, 0, 0, 0, "R9", 3);           // request held: no second grant
        access(1, 1, 0, 0, "R9");

        idle(2);
        finish_run();
    end

endmodule